// File: doc/BRIEF.md
# Signed-by-Unsigned Limb Multiply-Accumulate Step

This block computes one limb of a big-integer product in which the multiplicand limb is signed and the multiplier word is unsigned. It takes a multiplicand `ra`, a multiplier `rb` and a carry word `rc`, all `XLEN` bits wide. It forms a `2*XLEN`-bit result and splits it into a low word `rt` and a high carry-out word `rs`. A chain of these steps walks a multi-limb operand. Each step's `rs` feeds the next step's `rc`.

The carry word is not always added as it is. A high half that a signed-by-unsigned product produced is negative whenever its top bit is set. In that case the step uses `(rb + rc) mod 2^XLEN` as its addend in place of `rc`, with the upper addend half held at zero. This converts the carried value into the value an unsigned multiply would have left.

The block is built either as pure combinational logic or with one register stage behind a valid/ready handshake. The multiplier can be built in one of two forms: magnitude-and-negate, or direct sign extension.

Top module: `smul_step`

## Requirements
- R1: With `rc` zero, `{rs, rt}` equals the `2*XLEN`-bit two's-complement product of `ra` read as signed and `rb` read as unsigned.
- R2: With `rc[XLEN-1]` equal to 0, `rc` is zero-extended to `2*XLEN` bits and added to the product. For example, `ra`=0 gives `rt`=`rc` and `rs`=0.
- R3: With `rc[XLEN-1]` equal to 1, the addend is `(rb + rc) mod 2^XLEN` in the low half and zero in the high half. For example, `ra`=0 gives `rt`=`(rb+rc) mod 2^XLEN` and `rs`=0.
- R4: The most negative `ra` (only bit `XLEN-1` set) multiplies as `-2^(XLEN-1)` without overflow of the magnitude.
- R5: The sum of addend and product wraps modulo `2^(2*XLEN)`, and any carry out of the top bit is dropped.
- R6: In the registered build, `out_valid` is 1 in the cycle after an accepted input (`in_valid && in_ready`). It goes to 0 after a cycle with `out_ready` high and no new accept.
- R7: In the registered build, `rt` and `rs` keep their values until the next accepted input.
- R8: In the registered build, `in_ready` is 0 while `out_valid` is 1 and `out_ready` is 0. An input offered then is not taken.
- R9: While reset is asserted, and for the two clock edges after its release, `out_valid` and `in_ready` are 0.
- R10: In the combinational build, `rt` and `rs` follow the operands in the same cycle, `out_valid` equals `in_valid`, and both multiplier forms give identical results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (registered build) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are offered |
| in_ready | output | 1 | Block can take operands |
| ra | input | XLEN | Signed multiplicand limb |
| rb | input | XLEN | Unsigned multiplier word |
| rc | input | XLEN | Incoming carry word |
| out_valid | output | 1 | Result words are valid |
| out_ready | input | 1 | Consumer takes the result |
| rt | output | XLEN | Low result word |
| rs | output | XLEN | High carry-out word |

## Verification
The bench builds three copies of the block. At `XLEN`=8 there is a registered magnitude-form copy and a combinational sign-extension copy. These two see every one of the 65536 `ra`/`rb` pairs, with a carry that cycles both top-bit states. A further sweep covers all 256 carry values against the extreme multiplicands and multipliers. With this small width every sign, carry-correction and wrap case can be compared against arithmetic done in the bench at twice the width. A combinational copy at the default `XLEN`=64 takes a grid of corner operands checked with 128-bit arithmetic. The registered copy also goes through reset, back-pressure and drain sequences.

// File: rtl/smul_pkg.sv
`timescale 1ns/1ps
package smul_pkg;

  // How the signed-by-unsigned product is built.
  typedef enum logic {
    MUL_MAGNITUDE = 1'b0,  // |ra| * rb, negated when ra < 0
    MUL_SIGNEXT   = 1'b1   // sign-extended ra times zero-extended rb
  } mul_style_e;

endpackage

// File: rtl/smul_carry_fix.sv
`timescale 1ns/1ps
// Builds the 2*XLEN-bit addend from the incoming carry word.
module smul_carry_fix #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]   rb,
  input  logic [XLEN-1:0]   rc,
  output logic [2*XLEN-1:0] addend
);

  localparam int DW = 2 * XLEN;

  logic [XLEN-1:0] lo_fixed;
  logic            carry_neg;

  assign carry_neg = rc[XLEN-1];

  always_comb begin
    lo_fixed = rb + rc;
  end

  always_comb begin
    addend = DW'(rc);
    if (carry_neg) begin
      addend = {{XLEN{1'b0}}, lo_fixed};
    end
  end

endmodule

// File: rtl/smul_su_mult.sv
`timescale 1ns/1ps
// Signed (ra) by unsigned (rb) multiplier, 2*XLEN-bit two's-complement result.
module smul_su_mult
  import smul_pkg::*;
#(
  parameter int         XLEN  = 64,
  parameter mul_style_e STYLE = MUL_MAGNITUDE
) (
  input  logic [XLEN-1:0]   ra,
  input  logic [XLEN-1:0]   rb,
  output logic [2*XLEN-1:0] prod
);

  localparam int DW = 2 * XLEN;

  generate
    if (STYLE == MUL_MAGNITUDE) begin : g_mag
      logic            neg;
      logic [XLEN-1:0] mag;
      logic [DW-1:0]   uprod;

      assign neg = ra[XLEN-1];

      always_comb begin
        // Most negative value maps to 2^(XLEN-1), still representable unsigned.
        mag = neg ? (~ra + XLEN'(1)) : ra;
      end

      always_comb begin
        uprod = DW'(mag) * DW'(rb);
      end

      always_comb begin
        prod = neg ? (~uprod + DW'(1)) : uprod;
      end
    end else begin : g_sext
      logic [DW-1:0] ra_ext;
      logic [DW-1:0] rb_ext;

      assign ra_ext = {{XLEN{ra[XLEN-1]}}, ra};
      assign rb_ext = {{XLEN{1'b0}}, rb};

      always_comb begin
        prod = ra_ext * rb_ext;
      end
    end
  endgenerate

endmodule

// File: rtl/smul_acc_add.sv
`timescale 1ns/1ps
// Adds product and addend modulo 2^(2*XLEN) and splits the result into words.
module smul_acc_add #(
  parameter int XLEN = 64
) (
  input  logic [2*XLEN-1:0] addend,
  input  logic [2*XLEN-1:0] prod,
  output logic [XLEN-1:0]   lo,
  output logic [XLEN-1:0]   hi
);

  localparam int DW = 2 * XLEN;

  logic [DW-1:0] sum;

  always_comb begin
    sum = addend + prod;
  end

  assign lo = sum[XLEN-1:0];
  assign hi = sum[DW-1:XLEN];

endmodule

// File: rtl/smul_step.sv
`timescale 1ns/1ps
// One limb step of a signed-by-unsigned big-integer multiply-accumulate.
module smul_step
  import smul_pkg::*;
#(
  parameter int         XLEN       = 64,
  parameter bit         REGISTERED = 1'b1,
  parameter mul_style_e MUL_STYLE  = MUL_MAGNITUDE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] ra,
  input  logic [XLEN-1:0] rb,
  input  logic [XLEN-1:0] rc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] rt,
  output logic [XLEN-1:0] rs
);

  localparam int DW        = 2 * XLEN;
  localparam int SYNC_LEN  = 2;

  logic [DW-1:0]   addend;
  logic [DW-1:0]   prod;
  logic [XLEN-1:0] rt_c;
  logic [XLEN-1:0] rs_c;
  logic            rst_ok;
  logic            accept;

  smul_carry_fix #(.XLEN(XLEN)) u_fix (
    .rb     (rb),
    .rc     (rc),
    .addend (addend)
  );

  smul_su_mult #(.XLEN(XLEN), .STYLE(MUL_STYLE)) u_mul (
    .ra   (ra),
    .rb   (rb),
    .prod (prod)
  );

  smul_acc_add #(.XLEN(XLEN)) u_add (
    .addend (addend),
    .prod   (prod),
    .lo     (rt_c),
    .hi     (rs_c)
  );

  assign accept = in_valid && in_ready;

  generate
    if (REGISTERED) begin : g_reg
      logic [SYNC_LEN-1:0] rst_pipe;
      logic                vld_q;
      logic                vld_d;
      logic                data_en;
      logic [XLEN-1:0]     rt_q;
      logic [XLEN-1:0]     rs_q;

      // Reset release synchroniser.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rst_pipe <= '0;
        end else begin
          rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
        end
      end

      assign rst_ok   = rst_pipe[SYNC_LEN-1];
      assign in_ready = rst_ok && (!vld_q || out_ready);

      // Next-state logic.
      always_comb begin
        data_en = accept;
        if (accept) begin
          vld_d = 1'b1;
        end else if (out_ready) begin
          vld_d = 1'b0;
        end else begin
          vld_d = vld_q;
        end
      end

      // State registers.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          rt_q  <= '0;
          rs_q  <= '0;
        end else begin
          vld_q <= vld_d;
          if (data_en) begin
            rt_q <= rt_c;
            rs_q <= rs_c;
          end
        end
      end

      assign out_valid = vld_q;
      assign rt        = rt_q;
      assign rs        = rs_q;
    end else begin : g_comb
      assign rst_ok    = 1'b1;
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign rt        = rt_c;
      assign rs        = rs_c;
    end
  endgenerate

endmodule

// File: rtl/smul_step_chk.sv
`timescale 1ns/1ps
// Protocol and carry-correction checks for the registered build.
module smul_step_chk #(
  parameter int XLEN       = 64,
  parameter bit REGISTERED = 1'b1
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            in_valid,
  input logic            in_ready,
  input logic [XLEN-1:0] ra,
  input logic [XLEN-1:0] rb,
  input logic [XLEN-1:0] rc,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] rt,
  input logic [XLEN-1:0] rs
);

  logic acc_c;
  assign acc_c = in_valid && in_ready;

  generate
    if (REGISTERED) begin : g_chk
      // R6: a result appears the cycle after an accept.
      a_r6_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_ok)
        acc_c |=> out_valid);

      // R6: without accept and with the result consumed, valid drops.
      a_r6_drop_when_drained: assert property (@(posedge clk) disable iff (!rst_ok)
        (!acc_c && out_ready) |=> !out_valid);

      // R7: result words only change on an accept.
      a_r7_hold_words: assert property (@(posedge clk) disable iff (!rst_ok)
        !acc_c |=> ($stable(rt) && $stable(rs)));

      // R8: a stalled result blocks new input.
      a_r8_backpressure: assert property (@(posedge clk) disable iff (!rst_ok)
        (out_valid && !out_ready) |-> !in_ready);

      // R2: positive carry with zero multiplicand passes through.
      a_r2_plain_carry: assert property (@(posedge clk) disable iff (!rst_ok)
        (acc_c && ra == '0 && !rc[XLEN-1]) |=> (rs == '0 && rt == $past(rc)));

      // R3: negative carry is corrected to rb + rc.
      a_r3_corrected_carry: assert property (@(posedge clk) disable iff (!rst_ok)
        (acc_c && ra == '0 && rc[XLEN-1]) |=>
          (rs == '0 && rt == XLEN'($past(rb) + $past(rc))));
    end
  endgenerate

endmodule

bind smul_step smul_step_chk #(.XLEN(XLEN), .REGISTERED(REGISTERED)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .ra        (ra),
  .rb        (rb),
  .rc        (rc),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .rt        (rt),
  .rs        (rs)
);

// File: tb/sim_smul_step.sv
`timescale 1ns/1ps
module sim_smul_step;
  import smul_pkg::*;

  localparam time TCK = 20ns;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic       out_ready;
  logic [7:0] ra8, rb8, rc8;

  logic       u0_in_ready, u0_out_valid;
  logic [7:0] u0_rt, u0_rs;
  logic       u1_in_ready, u1_out_valid;
  logic [7:0] u1_rt, u1_rs;

  logic [63:0] ra64, rb64, rc64, u2_rt, u2_rs;
  logic        u2_in_ready, u2_out_valid;

  int nchk;
  int nerr;
  bit done;

  smul_step #(.XLEN(8), .REGISTERED(1'b1), .MUL_STYLE(MUL_MAGNITUDE)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(u0_in_ready),
    .ra(ra8), .rb(rb8), .rc(rc8), .out_valid(u0_out_valid),
    .out_ready(out_ready), .rt(u0_rt), .rs(u0_rs)
  );

  smul_step #(.XLEN(8), .REGISTERED(1'b0), .MUL_STYLE(MUL_SIGNEXT)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(u1_in_ready),
    .ra(ra8), .rb(rb8), .rc(rc8), .out_valid(u1_out_valid),
    .out_ready(1'b1), .rt(u1_rt), .rs(u1_rs)
  );

  smul_step #(.XLEN(64), .REGISTERED(1'b0), .MUL_STYLE(MUL_MAGNITUDE)) u2 (
    .clk(clk), .rst_n(rst_n), .in_valid(1'b1), .in_ready(u2_in_ready),
    .ra(ra64), .rb(rb64), .rc(rc64), .out_valid(u2_out_valid),
    .out_ready(1'b1), .rt(u2_rt), .rs(u2_rs)
  );

  initial clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  function automatic logic [15:0] ref8(input logic [7:0] a, b, c);
    logic [15:0] acc;
    logic [15:0] p;
    acc = {8'h00, c};
    if (c[7]) acc = {8'h00, 8'(b + c)};
    p = {{8{a[7]}}, a} * {8'h00, b};
    return acc + p;
  endfunction

  function automatic logic [127:0] ref64(input logic [63:0] a, b, c);
    logic [127:0] acc;
    logic [127:0] p;
    acc = {64'h0, c};
    if (c[63]) acc = {64'h0, 64'(b + c)};
    p = {{64{a[63]}}, a} * {64'h0, b};
    return acc + p;
  endfunction

  function automatic string tag8(input logic [7:0] a, b, c);
    logic [16:0] wide;
    logic [15:0] acc;
    acc = c[7] ? {8'h00, 8'(b + c)} : {8'h00, c};
    wide = {1'b0, acc} + {1'b0, 16'({{8{a[7]}}, a} * {8'h00, b})};
    if (a == 8'h80) return "R4";
    if (c[7]) return "R3";
    if (wide[16]) return "R5";
    if (c != 8'h00) return "R2";
    return "R1";
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic [15:0] exp_p;
  string       tag_p;
  bit          pend;

  // Called at a negedge: check the previous registered result, then offer a new one.
  task automatic step(input logic [7:0] a, b, c);
    logic [15:0] e;
    string t;
    if (pend) begin
      chk({"R6 ", tag_p, " valid"}, 128'(u0_out_valid), 128'(1));
      chk({tag_p, " u0 words"}, 128'({u0_rs, u0_rt}), 128'(exp_p));
    end
    ra8 = a; rb8 = b; rc8 = c; in_valid = 1'b1;
    #1;
    e = ref8(a, b, c);
    t = tag8(a, b, c);
    chk({"R10 ", t, " u1 words"}, 128'({u1_rs, u1_rt}), 128'(e));
    pend = 1'b1; exp_p = e; tag_p = t;
    @(negedge clk);
  endtask

  task automatic check64(input logic [63:0] a, b, c);
    string t;
    ra64 = a; rb64 = b; rc64 = c;
    #1;
    if (a == 64'h8000_0000_0000_0000) t = "R4 x64";
    else if (c[63]) t = "R3 x64";
    else if (c != 0) t = "R2 x64";
    else t = "R1 x64";
    chk(t, {u2_rs, u2_rt}, ref64(a, b, c));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(TCK * 200000);
    nerr++;
    $display("FAIL R6 watchdog act=running exp=finished");
    summary();
  end

  initial begin
    logic [7:0] ra_list [5];
    logic [7:0] rb_list [3];
    logic [63:0] a64 [6];
    logic [63:0] b64 [4];
    logic [63:0] c64 [5];
    nchk = 0; nerr = 0; done = 1'b0; pend = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    ra8 = 8'h00; rb8 = 8'h00; rc8 = 8'h00;
    ra64 = '0; rb64 = '0; rc64 = '0;

    repeat (3) @(negedge clk);
    // R9: idle in reset
    chk("R9 out_valid in reset", 128'(u0_out_valid), 128'(0));
    chk("R9 in_ready in reset", 128'(u0_in_ready), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 in_ready one edge after release", 128'(u0_in_ready), 128'(0));
    chk("R9 out_valid after release", 128'(u0_out_valid), 128'(0));
    @(negedge clk);
    @(negedge clk);
    chk("R8 in_ready after sync", 128'(u0_in_ready), 128'(1));

    // R10: combinational build mirrors in_valid
    chk("R10 u1 out_valid low", 128'(u1_out_valid), 128'(0));

    // Full ra x rb sweep, carry cycling through both top-bit states (R1..R5, R10).
    for (int i = 0; i < 65536; i++) begin
      step(8'(i >> 8), 8'(i), 8'((i * 37) ^ (i >> 9)));
    end

    // All carries against extreme operands (R3, R4).
    ra_list = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01};
    rb_list = '{8'h00, 8'hFF, 8'h01};
    for (int x = 0; x < 5; x++) begin
      for (int y = 0; y < 3; y++) begin
        for (int c = 0; c < 256; c++) begin
          step(ra_list[x], rb_list[y], 8'(c));
        end
      end
    end

    // Drain last result.
    chk({"R6 ", tag_p, " valid"}, 128'(u0_out_valid), 128'(1));
    chk({tag_p, " u0 words"}, 128'({u0_rs, u0_rt}), 128'(exp_p));
    pend = 1'b0;
    chk("R10 u1 out_valid high", 128'(u1_out_valid), 128'(1));

    // Back-pressure: new input offered while the result is stalled (R8, R7).
    out_ready = 1'b0;
    ra8 = 8'h03; rb8 = 8'h05; rc8 = 8'h00; in_valid = 1'b1;
    #1;
    chk("R8 in_ready low under stall", 128'(u0_in_ready), 128'(0));
    @(negedge clk);
    chk("R8 out_valid held under stall", 128'(u0_out_valid), 128'(1));
    chk("R7 words held, input ignored", 128'({u0_rs, u0_rt}), 128'(exp_p));
    out_ready = 1'b1;
    #1;
    chk("R8 in_ready back high", 128'(u0_in_ready), 128'(1));
    @(negedge clk);
    chk("R6 stalled input taken", 128'({u0_rs, u0_rt}), 128'(16'd15));
    in_valid = 1'b0;
    ra8 = 8'hAA; rb8 = 8'h55; rc8 = 8'h99;
    @(negedge clk);
    chk("R6 valid drops after drain", 128'(u0_out_valid), 128'(0));
    chk("R7 words held with no accept", 128'({u0_rs, u0_rt}), 128'(16'd15));
    #1;
    chk("R10 u1 out_valid follows in_valid", 128'(u1_out_valid), 128'(0));

    // XLEN=64 corner grid (R1..R5).
    a64 = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
            64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'hDEAD_BEEF_0123_4567};
    b64 = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h9E37_79B9_7F4A_7C15};
    c64 = '{64'h0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
            64'h1, 64'h7FFF_FFFF_FFFF_FFFF};
    for (int x = 0; x < 6; x++) begin
      for (int y = 0; y < 4; y++) begin
        for (int z = 0; z < 5; z++) begin
          check64(a64[x], b64[y], c64[z]);
        end
      end
    end
    // R4: -2^63 * (2^64-1) with zero carry = 2^63 in low word shifted result.
    check64(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    // R3: ra=0, corrected carry wraps in low word.
    check64(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001);

    @(negedge clk);
    summary();
  end

endmodule